// File: doc/BRIEF.md
# Twelve-Word OAN-XOR PUF Response Combiner

This block sequences and post-processes a composite physically unclonable function. When it accepts a 64-bit challenge, it obtains twelve 64-bit sub-challenges one after another from an expansion port. The block presents a slot index and the latched challenge on that port, and the expansion logic returns the sub-challenge word. It sends each sub-challenge to an external arbiter-style response source over a valid/ready request channel. It stores the 64-bit word that comes back on the response channel in the slot for that index.

When the twelfth word has been stored, a fixed network folds the twelve words into one 64-bit result. The network works the same way at every bit position: an AND of two words, a NAND of two more, an OR of two more, and a nine-input XOR. The XOR takes those three terms and the remaining six words. The result is shown with a one-cycle valid pulse.

A challenge flagged as invalid when it is offered is discarded. No request is issued for it, and the block raises a one-cycle drop pulse. A system controller offers challenges while the block is idle, waits for the valid pulse, and stores the challenge and result pair elsewhere.

Top module: `puf_oan_combiner`

## Requirements
- R1: A synchronous active-high reset returns the block to idle. In the cycle after a reset cycle, busy, drop, req_valid and out_valid are 0, exp_idx is 0, and out_data is 0. This also applies when the reset arrives in the middle of a sequence.
- R2: A challenge offered while idle with chal_ok = 0 is discarded. drop is 1 for exactly the one cycle after the offer. busy and req_valid stay 0, and no result is produced for that challenge.
- R3: A challenge offered while idle with chal_ok = 1 is accepted. In the next cycle busy is 1, req_valid is 1, exp_idx is 0, and exp_seed equals the offered challenge.
- R4: Exactly twelve requests are issued per accepted challenge, with exp_idx equal to 0, 1, …, 11 in that order. Each request's req_data equals exp_word. A new request is raised only after the response to the previous one has arrived.
- R5: While req_valid is 1 and req_ready is 0, req_valid stays 1 and req_data and exp_idx are held unchanged.
- R6: With slot k holding the response to the request with exp_idx = k, every bit b of the result is computed as follows: (s0[b] AND s1[b]) XOR NOT(s2[b] AND s3[b]) XOR (s4[b] OR s5[b]) XOR s6[b] XOR s7[b] XOR s8[b] XOR s9[b] XOR s10[b] XOR s11[b].
- R7: out_valid is a one-cycle pulse. It occurs exactly once per accepted challenge, after the twelfth response, and out_data carries the R6 result in that cycle.
- R8: busy stays 1 from the cycle after acceptance through the out_valid cycle, and is 0 in the cycle after. A challenge offered while busy is ignored: it produces neither a drop nor an extra result.
- R9: When all twelve responses are zero, every bit of the result is 1. When all twelve responses are all-ones, every bit of the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chal_valid | input | 1 | Challenge offered this cycle |
| chal_data | input | 64 | Challenge word |
| chal_ok | input | 1 | Validity flag sampled with the challenge |
| busy | output | 1 | A challenge is being processed |
| drop | output | 1 | One-cycle pulse for a discarded challenge |
| exp_idx | output | 4 | Sub-challenge index (0 to 11) for the expansion port |
| exp_seed | output | 64 | Latched challenge for the expansion port |
| exp_word | input | 64 | Sub-challenge returned by the expansion logic |
| req_valid | output | 1 | Sub-challenge request valid |
| req_ready | input | 1 | Response source accepts the request |
| req_data | output | 64 | Sub-challenge sent to the response source |
| rsp_valid | input | 1 | Response word valid |
| rsp_data | input | 64 | Response word |
| out_valid | output | 1 | One-cycle result valid pulse |
| out_data | output | 64 | Combined 64-bit result |

## Verification
The combiner is tried with three kinds of response stream:

- **Per-slot varied words.** A stand-in source returns words that differ for every slot and every challenge. These show whether each slot reaches its proper gate, because a swapped pair such as AND against NAND, or an XOR input that is lost, changes the expected result.
- **All-zero words.** These isolate the NAND term, which must make every bit 1.
- **All-ones words.** These show whether the OR and AND terms cancel against the six XOR inputs.

Two further dimensions are varied:

- **Handshake timing.** Ready stalls and response latencies are varied to separate held request data from data that changes early.
- **Challenge offers.** Rejected challenges, challenges offered while busy, and a reset in the middle of a sequence test whether a result can be lost or duplicated.

// File: rtl/puf_comb_pkg.sv
package puf_comb_pkg;

    localparam int N_SLOTS = 12;
    localparam int IDX_W   = $clog2(N_SLOTS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_AWAIT,
        ST_MERGE,
        ST_FLUSH
    } seq_state_t;

endpackage

// File: rtl/puf_slot_bank.sv
module puf_slot_bank
    import puf_comb_pkg::*;
#(
    parameter int W = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [W-1:0]                  wr_data,
    output logic [N_SLOTS-1:0][W-1:0]     slots_o
);

    logic [N_SLOTS-1:0][W-1:0] slots_d, slots_q;

    always_comb begin
        slots_d = slots_q;
        for (int k = 0; k < N_SLOTS; k++) begin
            if (wr_en && (wr_idx == IDX_W'(k))) begin
                slots_d[k] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
        end else begin
            slots_q <= slots_d;
        end
    end

    assign slots_o = slots_q;

endmodule

// File: rtl/puf_oan_merge.sv
module puf_oan_merge
    import puf_comb_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [N_SLOTS-1:0][W-1:0] slots_i,
    output logic [W-1:0]              merged_o
);

    localparam int FIRST_TAIL = 6;
    localparam int N_TAIL     = N_SLOTS - FIRST_TAIL;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic              and_t;
        logic              nand_t;
        logic              or_t;
        logic [N_TAIL-1:0] tail;

        assign and_t  = slots_i[0][b] & slots_i[1][b];
        assign nand_t = ~(slots_i[2][b] & slots_i[3][b]);
        assign or_t   = slots_i[4][b] | slots_i[5][b];

        for (genvar t = 0; t < N_TAIL; t++) begin : g_tail
            assign tail[t] = slots_i[FIRST_TAIL + t][b];
        end

        assign merged_o[b] = and_t ^ nand_t ^ or_t ^ (^tail);
    end

endmodule

// File: rtl/puf_issue_fsm.sv
module puf_issue_fsm
    import puf_comb_pkg::*;
#(
    parameter int W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chal_valid,
    input  logic [W-1:0]     chal_data,
    input  logic             chal_ok,
    input  logic             req_ready,
    input  logic             rsp_valid,
    input  logic [W-1:0]     merged_i,
    output logic             busy_o,
    output logic             drop_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [W-1:0]     seed_o,
    output logic             req_valid_o,
    output logic             wr_en_o,
    output logic             out_valid_o,
    output logic [W-1:0]     out_data_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SLOTS - 1);

    typedef struct packed {
        seq_state_t       st;
        logic [IDX_W-1:0] idx;
        logic [W-1:0]     seed;
        logic             drop;
        logic             ov;
        logic [W-1:0]     od;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic wr_en_d;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.drop = 1'b0;
        ctl_d.ov   = 1'b0;
        wr_en_d    = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (chal_valid) begin
                    if (chal_ok) begin
                        ctl_d.st   = ST_ISSUE;
                        ctl_d.seed = chal_data;
                        ctl_d.idx  = '0;
                    end else begin
                        ctl_d.drop = 1'b1;
                    end
                end
            end
            ST_ISSUE: begin
                if (req_ready) begin
                    ctl_d.st = ST_AWAIT;
                end
            end
            ST_AWAIT: begin
                if (rsp_valid) begin
                    wr_en_d = 1'b1;
                    if (ctl_q.idx == LAST_IDX) begin
                        ctl_d.st = ST_MERGE;
                    end else begin
                        ctl_d.idx = ctl_q.idx + 1'b1;
                        ctl_d.st  = ST_ISSUE;
                    end
                end
            end
            ST_MERGE: begin
                ctl_d.ov = 1'b1;
                ctl_d.od = merged_i;
                ctl_d.st = ST_FLUSH;
            end
            ST_FLUSH: begin
                ctl_d.idx = '0;
                ctl_d.st  = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.idx  <= '0;
            ctl_q.seed <= '0;
            ctl_q.drop <= 1'b0;
            ctl_q.ov   <= 1'b0;
            ctl_q.od   <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o      = (ctl_q.st != ST_IDLE);
    assign drop_o      = ctl_q.drop;
    assign idx_o       = ctl_q.idx;
    assign seed_o      = ctl_q.seed;
    assign req_valid_o = (ctl_q.st == ST_ISSUE);
    assign wr_en_o     = wr_en_d;
    assign out_valid_o = ctl_q.ov;
    assign out_data_o  = ctl_q.od;

endmodule

// File: rtl/puf_oan_combiner.sv
module puf_oan_combiner
    import puf_comb_pkg::*;
#(
    parameter int W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chal_valid,
    input  logic [W-1:0]     chal_data,
    input  logic             chal_ok,
    output logic             busy,
    output logic             drop,
    output logic [IDX_W-1:0] exp_idx,
    output logic [W-1:0]     exp_seed,
    input  logic [W-1:0]     exp_word,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [W-1:0]     req_data,
    input  logic             rsp_valid,
    input  logic [W-1:0]     rsp_data,
    output logic             out_valid,
    output logic [W-1:0]     out_data
);

    logic                      wr_en;
    logic [N_SLOTS-1:0][W-1:0] slots;
    logic [W-1:0]              merged;

    puf_issue_fsm #(.W(W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .chal_valid (chal_valid),
        .chal_data  (chal_data),
        .chal_ok    (chal_ok),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .merged_i   (merged),
        .busy_o     (busy),
        .drop_o     (drop),
        .idx_o      (exp_idx),
        .seed_o     (exp_seed),
        .req_valid_o(req_valid),
        .wr_en_o    (wr_en),
        .out_valid_o(out_valid),
        .out_data_o (out_data)
    );

    puf_slot_bank #(.W(W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (exp_idx),
        .wr_data(rsp_data),
        .slots_o(slots)
    );

    puf_oan_merge #(.W(W)) u_merge (
        .slots_i (slots),
        .merged_o(merged)
    );

    assign req_data = exp_word;

endmodule

// File: rtl/puf_oan_combiner_chk.sv
module puf_oan_combiner_chk
    import puf_comb_pkg::*;
#(
    parameter int W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             drop,
    input logic [IDX_W-1:0] exp_idx,
    input logic             req_valid,
    input logic             req_ready,
    input logic [W-1:0]     req_data,
    input logic             out_valid
);

    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !drop && !req_valid && !out_valid && exp_idx == '0));

    p_drop_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        drop |=> !drop);

    p_drop_idle_r2: assert property (@(posedge clk) disable iff (rst)
        drop |-> (!busy && !req_valid));

    p_req_needs_busy_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> busy);

    p_idx_range_r4: assert property (@(posedge clk) disable iff (rst)
        exp_idx <= IDX_W'(N_SLOTS - 1));

    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_data) && $stable(exp_idx)));

    p_out_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    p_busy_at_out_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (busy && !req_valid));

    p_busy_after_out_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !busy);

endmodule

bind puf_oan_combiner puf_oan_combiner_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .drop     (drop),
    .exp_idx  (exp_idx),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_data (req_data),
    .out_valid(out_valid)
);

// File: tb/puf_oan_combiner_tb_top.sv
`timescale 1ns/1ps
module puf_oan_combiner_tb_top;

    localparam int W        = 64;
    localparam int NS       = 12;
    localparam int WD_LIMIT = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chal_valid = 1'b0;
    logic [W-1:0]  chal_data  = '0;
    logic          chal_ok    = 1'b0;
    logic          busy, drop, req_valid, out_valid;
    logic [3:0]    exp_idx;
    logic [W-1:0]  exp_seed, exp_word, req_data, out_data;
    logic          req_ready = 1'b0;
    logic          rsp_valid = 1'b0;
    logic [W-1:0]  rsp_data  = '0;

    always #4 clk = ~clk;

    puf_oan_combiner #(.W(W)) dut_i (
        .clk(clk), .rst(rst),
        .chal_valid(chal_valid), .chal_data(chal_data), .chal_ok(chal_ok),
        .busy(busy), .drop(drop),
        .exp_idx(exp_idx), .exp_seed(exp_seed), .exp_word(exp_word),
        .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // stand-in expansion and response source
    function automatic logic [W-1:0] expand(input logic [W-1:0] c, input int k);
        return c ^ (64'h9E3779B97F4A7C15 * 64'(k + 1));
    endfunction

    int mode = 0;  // 0 varied, 1 all zero, 2 all ones
    function automatic logic [W-1:0] resp_fn(input int k, input logic [W-1:0] d);
        if (mode == 1) return '0;
        if (mode == 2) return '1;
        return {d[W-2:0], d[W-1]} ^ {16{4'(k)}} ^ 64'h0F0F_3C3C_5A5A_C3C3;
    endfunction

    function automatic logic [W-1:0] combine(input logic [W-1:0] c);
        logic [W-1:0] s [NS];
        logic [W-1:0] r;
        for (int k = 0; k < NS; k++) s[k] = resp_fn(k, expand(c, k));
        r = (s[0] & s[1]) ^ ~(s[2] & s[3]) ^ (s[4] | s[5]);
        for (int k = 6; k < NS; k++) r = r ^ s[k];
        return r;
    endfunction

    assign exp_word = expand(exp_seed, int'(exp_idx));

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // scoreboard
    logic [W-1:0] exp_q [$];
    string        tag_q [$];
    int           n_pushed = 0;
    int           n_seen   = 0;

    logic [W-1:0] cur_chal = '0;
    int           req_n    = 0;
    int           stall_cfg = 0;
    int           lat_cfg   = 0;

    // responder
    initial begin
        bit           waiting = 0;
        bit           seen    = 0;
        int           stall_left = 0;
        int           lat_cnt = 0;
        int           cap_idx = 0;
        logic [W-1:0] cap_d = '0;
        logic [W-1:0] held  = '0;
        forever begin
            @(negedge clk);
            if (rst) begin
                req_ready = 0; rsp_valid = 0; waiting = 0; seen = 0;
                continue;
            end
            rsp_valid = 0;
            if (req_ready) begin
                req_ready = 0;
                waiting   = 1;
                lat_cnt   = lat_cfg;
            end else if (waiting) begin
                if (lat_cnt == 0) begin
                    rsp_valid = 1;
                    rsp_data  = resp_fn(cap_idx, cap_d);
                    waiting   = 0;
                end else begin
                    lat_cnt--;
                end
            end else if (req_valid) begin
                if (!seen) begin
                    seen = 1; stall_left = stall_cfg; held = req_data;
                end
                if (stall_left > 0) begin
                    check(req_data === held && req_valid, "R5 held request", req_data, held);
                    stall_left--;
                end else begin
                    check(exp_idx == 4'(req_n), "R4 index order", 64'(exp_idx), 64'(req_n));
                    check(req_data === expand(cur_chal, req_n), "R4 request data",
                          req_data, expand(cur_chal, req_n));
                    cap_idx   = req_n;
                    cap_d     = req_data;
                    req_n++;
                    req_ready = 1;
                    seen      = 0;
                end
            end
        end
    end

    // monitor
    initial begin
        bit prev_ov = 0;
        forever begin
            @(negedge clk);
            if (rst) begin prev_ov = 0; continue; end
            if (prev_ov) check(busy == 1'b0, "R8 busy low after result", 64'(busy), 64'd0);
            if (out_valid) begin
                n_seen++;
                check(busy == 1'b1, "R8 busy during result", 64'(busy), 64'd1);
                check(req_n == NS, "R4 twelve requests", 64'(req_n), 64'(NS));
                if (exp_q.size() == 0) begin
                    check(0, "R7 unexpected result", out_data, '0);
                end else begin
                    logic [W-1:0] e;
                    string        t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_data === e, t, out_data, e);
                end
            end
            prev_ov = out_valid;
        end
    end

    task automatic offer(input logic [W-1:0] c, input bit ok);
        @(negedge clk);
        while (busy) @(negedge clk);
        chal_valid = 1; chal_data = c; chal_ok = ok;
        if (ok) begin
            cur_chal = c; req_n = 0;
            exp_q.push_back(combine(c));
            tag_q.push_back(mode == 0 ? "R6 merged result" : "R9 uniform responses");
            n_pushed++;
        end
        @(negedge clk);
        chal_valid = 0; chal_ok = 0;
        if (ok) begin
            check(busy && req_valid, "R3 accept starts request", {62'd0, busy, req_valid}, 64'd3);
            check(exp_idx == 4'd0, "R3 first index", 64'(exp_idx), 64'd0);
            check(exp_seed === c, "R3 latched challenge", exp_seed, c);
        end else begin
            check(drop == 1'b1, "R2 drop pulse", 64'(drop), 64'd1);
            check(!busy && !req_valid, "R2 nothing issued", {62'd0, busy, req_valid}, 64'd0);
            @(negedge clk);
            check(drop == 1'b0, "R2 drop one cycle", 64'(drop), 64'd0);
            check(!busy && !req_valid, "R2 stays idle", {62'd0, busy, req_valid}, 64'd0);
        end
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WD_LIMIT, 0);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!busy && !drop && !req_valid && !out_valid, "R1 reset state",
              {60'd0, busy, drop, req_valid, out_valid}, 64'd0);
        check(out_data === '0 && exp_idx == 4'd0, "R1 reset data", out_data, '0);

        // varied responses, fast handshake
        offer(64'h0123_4567_89AB_CDEF, 1); drain();
        // rejected challenge
        offer(64'hDEAD_BEEF_0000_1111, 0);
        repeat (20) @(negedge clk);
        check(n_seen == n_pushed, "R2 no result for rejected", 64'(n_seen), 64'(n_pushed));
        // stalls and latency
        stall_cfg = 3; lat_cfg = 2;
        offer(64'hFFFF_0000_AAAA_5555, 1); drain();
        stall_cfg = 1; lat_cfg = 5;
        offer(64'h8000_0000_0000_0001, 1); drain();
        stall_cfg = 0; lat_cfg = 0;
        // offers while busy are ignored
        offer(64'h1357_9BDF_2468_ACE0, 1);
        chal_valid = 1; chal_data = 64'hCAFE_F00D_CAFE_F00D; chal_ok = 1;
        repeat (4) begin
            @(negedge clk);
            check(drop == 1'b0, "R8 no drop while busy", 64'(drop), 64'd0);
        end
        chal_ok = 0;
        repeat (2) @(negedge clk);
        chal_valid = 0;
        drain();
        check(n_seen == n_pushed, "R7 one result per accepted", 64'(n_seen), 64'(n_pushed));
        // uniform responses
        mode = 1; offer(64'h5555_AAAA_5555_AAAA, 1); drain();
        mode = 2; offer(64'h0F0F_0F0F_F0F0_F0F0, 1); drain();
        mode = 0;
        // reset mid-sequence
        lat_cfg = 3;
        offer(64'h1111_2222_3333_4444, 1);
        repeat (10) @(negedge clk);
        rst = 1;
        exp_q.delete(); tag_q.delete(); n_pushed--;
        @(negedge clk); @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!busy && !req_valid && !out_valid && exp_idx == 4'd0, "R1 mid-run reset",
              {59'd0, busy, req_valid, out_valid, (exp_idx != 4'd0)}, 64'd0);
        lat_cfg = 1;
        offer(64'hA5A5_0000_FFFF_1234, 1); drain();
        check(n_seen == n_pushed, "R7 final result count", 64'(n_seen), 64'(n_pushed));

        done = 1;
        summary();
        $finish;
    end

endmodule